// File: doc/BRIEF.md
# Retirement-Based Watchpoint Event Reporter

This block sits between the debug match comparators and the retirement stage of an out-of-order core. A comparator that detects a watchpoint or breakpoint condition sends a match marked with the identifier (tag) of the in-flight instruction that caused it. The block keeps these matches in a per-tag pending record until that instruction retires. It then reports them, one report lane per retirement port, and up to two instructions may retire in the same clock. When a flush discards the in-flight instructions, their pending matches are dropped and never reported or counted. The block has no back-pressure path, so retirement is never stalled.

Repeated matches of one type inside a single instruction collapse into one report bit and one counter decrement. This happens, for example, across the many transfers of a load/store multiple. There is one event counter per type: a saturating down-counter with a load input and a zero flag. The block also raises a break request. An instruction breakpoint is a "before" break: the tagged instruction does not execute. A load/store breakpoint is an "after" break, raised once the whole instruction has retired. An after break also loads the breakpoint address register with the address of the first matching transfer.

Top module: `wpr_reporter`

## Requirements
- R1: During and directly after reset, `rep_valid_o`, `rep_type_o`, `brk_req_o`, `brk_after_o`, `brk_addr_o` and every counter are zero, and every bit of `cnt_zero_o` is 1.
- R2: A match is reported only when its tag retires. Its type bits appear on `rep_type_o` in the cycle after the retiring clock edge. Bit `p*NTYPE+t` is type `t` on retire port `p`, and `rep_valid_o[p]` marks a reported retirement.
- R3: Several matches of the same type on one tag produce a single report bit and decrement that type's counter by exactly one.
- R4: Two instructions retiring in the same clock are both reported in the same cycle. A counter whose type both of them carry decrements by two. Port 1 is used only together with port 0.
- R5: `flush_i` drops every pending match and any match presented in the same clock. Later retirement of the flushed tags reports no types and changes no counter.
- R6: An instruction breakpoint on a retiring instruction gives `brk_req_o`=1 with `brk_after_o`=0 (before) and leaves `brk_addr_o` unchanged.
- R7: A load/store breakpoint gives `brk_req_o`=1 with `brk_after_o`=1 (after) only when the instruction retires. `brk_addr_o` is then loaded with the address of the first load/store-breakpoint transfer of that instruction. `brk_addr_o` changes at no other time.
- R8: When the instruction on port 0 carries a breakpoint, the instruction retiring on port 1 in the same clock is cancelled. It gives no report, no count and no break.
- R9: When one instruction carries both breakpoint kinds, the before break wins and `brk_addr_o` is unchanged.
- R10: A counter load (`cnt_load_i[t]`) takes priority over a decrement in the same clock. Decrementing saturates at zero. `cnt_zero_o[t]` is 1 exactly when counter `t` is zero. Counter `t` is shown at `cnt_o[t*CNT_W +: CNT_W]`.
- R11: A match presented in the same clock in which its tag retires is merged into that retirement's report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard all in-flight instructions |
| match_valid_i | input | 1 | Comparator match present |
| match_tag_i | input | TAG_W | Tag of the matching instruction |
| match_type_i | input | NTYPE | Watchpoint types matched |
| match_ibrk_i | input | 1 | Instruction breakpoint match |
| match_lbrk_i | input | 1 | Load/store breakpoint match |
| match_addr_i | input | ADDR_W | Address of the matching transfer |
| ret_valid_i | input | NRET | Retirement port valid |
| ret_tag_i | input | NRET*TAG_W | Retiring tags, port p at p*TAG_W |
| cnt_load_i | input | NTYPE | Load strobe per counter |
| cnt_load_val_i | input | CNT_W | Counter load value |
| rep_valid_o | output | NRET | Reported retirement per port |
| rep_type_o | output | NRET*NTYPE | Reported types per port |
| brk_req_o | output | 1 | Break request pulse |
| brk_after_o | output | 1 | 1 = after break, 0 = before break |
| brk_addr_o | output | ADDR_W | Breakpoint address register |
| cnt_o | output | NTYPE*CNT_W | Counter values |
| cnt_zero_o | output | NTYPE | Counter at zero |

## Verification
The bench repeats one type across several transfers of a tag. A design without deduplication would decrement twice. It flushes with matches both pending and arriving, so a missing drop would show stale types at retirement. It sends two load/store-breakpoint transfers with different addresses, which exposes a register that keeps the last address or updates before retirement. It pairs a breaking older instruction with a younger one, sets both breakpoint kinds on one instruction, and drives counters through a two-step decrement from one and a load in the same clock as a hit. These cases catch counters that wrap, that lose the load, or that still count a cancelled instruction.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
  localparam int unsigned RET_PORTS = 2;

  typedef enum logic {
    BRK_BEFORE = 1'b0,
    BRK_AFTER  = 1'b1
  } brk_kind_e;
endpackage

// File: rtl/wpr_slot_file.sv
module wpr_slot_file #(
  parameter int unsigned TAG_W  = 3,
  parameter int unsigned NTYPE  = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NRET   = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic                   m_valid_i,
  input  logic [TAG_W-1:0]       m_tag_i,
  input  logic [NTYPE-1:0]       m_type_i,
  input  logic                   m_ibrk_i,
  input  logic                   m_lbrk_i,
  input  logic [ADDR_W-1:0]      m_addr_i,
  input  logic [NRET-1:0]        r_valid_i,
  input  logic [NRET*TAG_W-1:0]  r_tag_i,
  output logic [NRET*NTYPE-1:0]  r_type_o,
  output logic [NRET-1:0]        r_ibrk_o,
  output logic [NRET-1:0]        r_lbrk_o,
  output logic [NRET*ADDR_W-1:0] r_addr_o
);
  localparam int unsigned NSLOT = 2 ** TAG_W;

  logic [NTYPE-1:0]  pend_q [NSLOT];
  logic [ADDR_W-1:0] addr_q [NSLOT];
  logic [NSLOT-1:0]  ibrk_q, lbrk_q, ret_hit;
  logic              m_live;
  logic              any_pend;

  assign m_live = m_valid_i & ~flush_i;

  always_comb begin
    ret_hit = '0;
    for (int p = 0; p < NRET; p++)
      if (r_valid_i[p]) ret_hit[r_tag_i[p*TAG_W +: TAG_W]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ibrk_q <= '0;
      lbrk_q <= '0;
      for (int s = 0; s < NSLOT; s++) begin
        pend_q[s] <= '0;
        addr_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        if (flush_i || ret_hit[s]) begin
          pend_q[s] <= '0;
          ibrk_q[s] <= 1'b0;
          lbrk_q[s] <= 1'b0;
        end else if (m_live && m_tag_i == TAG_W'(s)) begin
          pend_q[s] <= pend_q[s] | m_type_i;  // duplicates merge
          ibrk_q[s] <= ibrk_q[s] | m_ibrk_i;
          if (m_lbrk_i && !lbrk_q[s]) begin
            lbrk_q[s] <= 1'b1;
            addr_q[s] <= m_addr_i;            // first transfer only
          end
        end
      end
    end
  end

  // read with bypass of a same-cycle match
  always_comb begin
    for (int p = 0; p < NRET; p++) begin
      logic [TAG_W-1:0] t;
      logic             byp;
      t   = r_tag_i[p*TAG_W +: TAG_W];
      byp = m_live && (m_tag_i == t);
      r_type_o[p*NTYPE +: NTYPE]   = pend_q[t] | (byp ? m_type_i : '0);
      r_ibrk_o[p]                  = ibrk_q[t] | (byp & m_ibrk_i);
      r_lbrk_o[p]                  = lbrk_q[t] | (byp & m_lbrk_i);
      r_addr_o[p*ADDR_W +: ADDR_W] = lbrk_q[t] ? addr_q[t] : m_addr_i;
    end
  end

  always_comb begin
    any_pend = |ibrk_q | |lbrk_q;
    for (int s = 0; s < NSLOT; s++) any_pend = any_pend | (|pend_q[s]);
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !any_pend);  // R5
endmodule

// File: rtl/wpr_retire_merge.sv
module wpr_retire_merge #(
  parameter int unsigned NTYPE  = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NRET   = 2
) (
  input  logic [NRET-1:0]        r_valid_i,
  input  logic [NRET*NTYPE-1:0]  r_type_i,
  input  logic [NRET-1:0]        r_ibrk_i,
  input  logic [NRET-1:0]        r_lbrk_i,
  input  logic [NRET*ADDR_W-1:0] r_addr_i,
  output logic [NRET-1:0]        e_valid_o,
  output logic [NRET*NTYPE-1:0]  e_type_o,
  output logic                   b_req_o,
  output wpr_pkg::brk_kind_e     b_kind_o,
  output logic [ADDR_W-1:0]      b_addr_o
);
  import wpr_pkg::*;

  always_comb begin
    logic blocked;
    blocked   = 1'b0;
    e_valid_o = '0;
    e_type_o  = '0;
    b_req_o   = 1'b0;
    b_kind_o  = BRK_BEFORE;
    b_addr_o  = '0;
    for (int p = 0; p < NRET; p++) begin
      e_valid_o[p] = r_valid_i[p] & ~blocked;
      if (e_valid_o[p]) begin
        e_type_o[p*NTYPE +: NTYPE] = r_type_i[p*NTYPE +: NTYPE];
        if (r_ibrk_i[p] || r_lbrk_i[p]) begin
          b_req_o  = 1'b1;
          b_kind_o = r_ibrk_i[p] ? BRK_BEFORE : BRK_AFTER;  // before wins
          b_addr_o = r_addr_i[p*ADDR_W +: ADDR_W];
          blocked  = 1'b1;  // younger ports are cancelled by the break
        end
      end
    end
  end
endmodule

// File: rtl/wpr_event_counter.sv
module wpr_event_counter #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned NRET  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [NRET-1:0]  hit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  localparam int unsigned DW = $clog2(NRET + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]    dec;

  always_comb begin
    dec = '0;
    for (int p = 0; p < NRET; p++) dec = dec + DW'(hit_i[p]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= load_val_i;
    else if (cnt_q < CNT_W'(dec)) cnt_q <= '0;
    else                          cnt_q <= cnt_q - CNT_W'(dec);
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);  // R10
  AST_ONLY_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (cnt_q <= $past(cnt_q)));  // R3
endmodule

// File: rtl/wpr_reporter.sv
module wpr_reporter
  import wpr_pkg::*;
#(
  parameter int unsigned TAG_W  = 3,
  parameter int unsigned NTYPE  = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NRET   = RET_PORTS
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic                    match_valid_i,
  input  logic [TAG_W-1:0]        match_tag_i,
  input  logic [NTYPE-1:0]        match_type_i,
  input  logic                    match_ibrk_i,
  input  logic                    match_lbrk_i,
  input  logic [ADDR_W-1:0]       match_addr_i,
  input  logic [NRET-1:0]         ret_valid_i,
  input  logic [NRET*TAG_W-1:0]   ret_tag_i,
  input  logic [NTYPE-1:0]        cnt_load_i,
  input  logic [CNT_W-1:0]        cnt_load_val_i,
  output logic [NRET-1:0]         rep_valid_o,
  output logic [NRET*NTYPE-1:0]   rep_type_o,
  output logic                    brk_req_o,
  output logic                    brk_after_o,
  output logic [ADDR_W-1:0]       brk_addr_o,
  output logic [NTYPE*CNT_W-1:0]  cnt_o,
  output logic [NTYPE-1:0]        cnt_zero_o
);
  logic [NRET*NTYPE-1:0]  rd_type, ev_type;
  logic [NRET-1:0]        rd_ibrk, rd_lbrk, ev_valid;
  logic [NRET*ADDR_W-1:0] rd_addr;
  logic                   b_req;
  brk_kind_e              b_kind;
  logic [ADDR_W-1:0]      b_addr;

  wpr_slot_file #(
    .TAG_W(TAG_W), .NTYPE(NTYPE), .ADDR_W(ADDR_W), .NRET(NRET)
  ) i_slots (
    .clk_i, .rst_ni, .flush_i,
    .m_valid_i (match_valid_i),
    .m_tag_i   (match_tag_i),
    .m_type_i  (match_type_i),
    .m_ibrk_i  (match_ibrk_i),
    .m_lbrk_i  (match_lbrk_i),
    .m_addr_i  (match_addr_i),
    .r_valid_i (ret_valid_i),
    .r_tag_i   (ret_tag_i),
    .r_type_o  (rd_type),
    .r_ibrk_o  (rd_ibrk),
    .r_lbrk_o  (rd_lbrk),
    .r_addr_o  (rd_addr)
  );

  wpr_retire_merge #(
    .NTYPE(NTYPE), .ADDR_W(ADDR_W), .NRET(NRET)
  ) i_merge (
    .r_valid_i (ret_valid_i),
    .r_type_i  (rd_type),
    .r_ibrk_i  (rd_ibrk),
    .r_lbrk_i  (rd_lbrk),
    .r_addr_i  (rd_addr),
    .e_valid_o (ev_valid),
    .e_type_o  (ev_type),
    .b_req_o   (b_req),
    .b_kind_o  (b_kind),
    .b_addr_o  (b_addr)
  );

  for (genvar t = 0; t < NTYPE; t++) begin : g_cnt
    logic [NRET-1:0] hit;
    for (genvar p = 0; p < NRET; p++) begin : g_hit
      assign hit[p] = ev_type[p*NTYPE + t];
    end
    wpr_event_counter #(.CNT_W(CNT_W), .NRET(NRET)) i_cnt (
      .clk_i, .rst_ni,
      .load_i     (cnt_load_i[t]),
      .load_val_i (cnt_load_val_i),
      .hit_i      (hit),
      .cnt_o      (cnt_o[t*CNT_W +: CNT_W]),
      .zero_o     (cnt_zero_o[t])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_valid_o <= '0;
      rep_type_o  <= '0;
      brk_req_o   <= 1'b0;
      brk_after_o <= 1'b0;
      brk_addr_o  <= '0;
    end else begin
      rep_valid_o <= ev_valid;
      rep_type_o  <= ev_type;
      brk_req_o   <= b_req;
      brk_after_o <= b_req && (b_kind == BRK_AFTER);
      if (b_req && b_kind == BRK_AFTER) brk_addr_o <= b_addr;
    end
  end

  AST_RET_IN_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i & (ret_valid_i + 1'b1)) == '0);  // R4
  AST_AFTER_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_after_o |-> brk_req_o);  // R6
  AST_BAR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(brk_req_o && brk_after_o) |-> $stable(brk_addr_o));  // R7
  AST_REP_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rep_valid_o[0] |-> (rep_type_o[NTYPE-1:0] == '0));  // R2
endmodule

// File: tb/test_wpr_reporter.sv
module test_wpr_reporter;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i;
  logic        match_valid_i;
  logic [2:0]  match_tag_i;
  logic [3:0]  match_type_i;
  logic        match_ibrk_i, match_lbrk_i;
  logic [31:0] match_addr_i;
  logic [1:0]  ret_valid_i;
  logic [5:0]  ret_tag_i;
  logic [3:0]  cnt_load_i;
  logic [15:0] cnt_load_val_i;
  logic [1:0]  rep_valid_o;
  logic [7:0]  rep_type_o;
  logic        brk_req_o, brk_after_o;
  logic [31:0] brk_addr_o;
  logic [63:0] cnt_o;
  logic [3:0]  cnt_zero_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wpr_reporter i_wpr_reporter (.*);

  typedef struct packed {
    logic        mv;
    logic [2:0]  mt;
    logic [3:0]  mty;
    logic        mib;
    logic        mlb;
    logic [15:0] ma;
    logic        fl;
    logic [1:0]  rv;
    logic [2:0]  rt0;
    logic [2:0]  rt1;
    logic [1:0]  erv;
    logic [7:0]  eev;
    logic        eb;
    logic        ea;
    logic [15:0] eaddr;
  } vec_t;

  localparam vec_t VECS [0:21] = '{
    '{1'b1,3'd1,4'h1,1'b0,1'b0,16'h0000,1'b0,2'b00,3'd0,3'd0, 2'b00,8'h00,1'b0,1'b0,16'h0000}, // R2 held
    '{1'b1,3'd1,4'h1,1'b0,1'b0,16'h0000,1'b0,2'b00,3'd0,3'd0, 2'b00,8'h00,1'b0,1'b0,16'h0000}, // R3 dup
    '{1'b1,3'd2,4'h2,1'b0,1'b0,16'h0000,1'b0,2'b00,3'd0,3'd0, 2'b00,8'h00,1'b0,1'b0,16'h0000},
    '{1'b0,3'd0,4'h0,1'b0,1'b0,16'h0000,1'b0,2'b01,3'd1,3'd0, 2'b01,8'h01,1'b0,1'b0,16'h0000}, // R2 R3
    '{1'b0,3'd0,4'h0,1'b0,1'b0,16'h0000,1'b0,2'b00,3'd0,3'd0, 2'b00,8'h00,1'b0,1'b0,16'h0000},
    '{1'b1,3'd3,4'h4,1'b0,1'b0,16'h0000,1'b0,2'b01,3'd2,3'd0, 2'b01,8'h02,1'b0,1'b0,16'h0000},
    '{1'b1,3'd4,4'h8,1'b0,1'b0,16'h0000,1'b0,2'b00,3'd0,3'd0, 2'b00,8'h00,1'b0,1'b0,16'h0000},
    '{1'b0,3'd0,4'h0,1'b0,1'b0,16'h0000,1'b0,2'b11,3'd3,3'd4, 2'b11,8'h84,1'b0,1'b0,16'h0000}, // R4
    '{1'b1,3'd5,4'h1,1'b0,1'b0,16'h0000,1'b0,2'b00,3'd0,3'd0, 2'b00,8'h00,1'b0,1'b0,16'h0000},
    '{1'b1,3'd6,4'h2,1'b0,1'b0,16'h0000,1'b1,2'b00,3'd0,3'd0, 2'b00,8'h00,1'b0,1'b0,16'h0000}, // R5 flush
    '{1'b0,3'd0,4'h0,1'b0,1'b0,16'h0000,1'b0,2'b11,3'd5,3'd6, 2'b11,8'h00,1'b0,1'b0,16'h0000}, // R5
    '{1'b1,3'd7,4'h1,1'b0,1'b1,16'h1234,1'b0,2'b00,3'd0,3'd0, 2'b00,8'h00,1'b0,1'b0,16'h0000}, // R7
    '{1'b1,3'd7,4'h1,1'b0,1'b1,16'h5678,1'b0,2'b00,3'd0,3'd0, 2'b00,8'h00,1'b0,1'b0,16'h0000},
    '{1'b0,3'd0,4'h0,1'b0,1'b0,16'h0000,1'b0,2'b01,3'd7,3'd0, 2'b01,8'h01,1'b1,1'b1,16'h1234}, // R7 first addr
    '{1'b1,3'd0,4'h0,1'b1,1'b0,16'h0000,1'b0,2'b00,3'd0,3'd0, 2'b00,8'h00,1'b0,1'b0,16'h1234},
    '{1'b1,3'd1,4'h2,1'b0,1'b0,16'h0000,1'b0,2'b00,3'd0,3'd0, 2'b00,8'h00,1'b0,1'b0,16'h1234},
    '{1'b0,3'd0,4'h0,1'b0,1'b0,16'h0000,1'b0,2'b11,3'd0,3'd1, 2'b01,8'h00,1'b1,1'b0,16'h1234}, // R6 R8
    '{1'b1,3'd2,4'h0,1'b1,1'b1,16'h9999,1'b0,2'b00,3'd0,3'd0, 2'b00,8'h00,1'b0,1'b0,16'h1234},
    '{1'b0,3'd0,4'h0,1'b0,1'b0,16'h0000,1'b0,2'b01,3'd2,3'd0, 2'b01,8'h00,1'b1,1'b0,16'h1234}, // R9
    '{1'b1,3'd3,4'h4,1'b0,1'b0,16'h0000,1'b0,2'b01,3'd3,3'd0, 2'b01,8'h04,1'b0,1'b0,16'h1234}, // R11
    '{1'b0,3'd0,4'h0,1'b0,1'b0,16'h0000,1'b0,2'b00,3'd0,3'd0, 2'b00,8'h00,1'b0,1'b0,16'h1234},
    '{1'b0,3'd0,4'h0,1'b0,1'b0,16'h0000,1'b0,2'b01,3'd1,3'd0, 2'b01,8'h00,1'b0,1'b0,16'h1234}  // R8 slot gone
  };

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic idle();
    flush_i = 0; match_valid_i = 0; match_tag_i = 0; match_type_i = 0;
    match_ibrk_i = 0; match_lbrk_i = 0; match_addr_i = 0;
    ret_valid_i = 0; ret_tag_i = 0; cnt_load_i = 0; cnt_load_val_i = 0;
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic put_match(input logic [2:0] tag, input logic [3:0] ty);
    idle();
    match_valid_i = 1; match_tag_i = tag; match_type_i = ty;
    tick();
  endtask

  task automatic retire2(input logic [2:0] t0, input logic [2:0] t1);
    idle();
    ret_valid_i = 2'b11; ret_tag_i = {t1, t0};
    tick();
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    check("R1 rep_valid", 64'(rep_valid_o), 0);
    check("R1 brk_req", 64'(brk_req_o), 0);
    check("R1 brk_addr", 64'(brk_addr_o), 0);
    check("R1 cnt", cnt_o, 0);
    check("R1 zero", 64'(cnt_zero_o), 64'hF);
    rst_ni = 1;
    tick();
    check("R1 after release", 64'({rep_valid_o, rep_type_o, brk_req_o, brk_after_o}), 0);

    // R10 load all counters
    idle(); cnt_load_i = 4'hF; cnt_load_val_i = 16'd5;
    tick();
    check("R10 load", cnt_o, {16'd5, 16'd5, 16'd5, 16'd5});
    check("R10 zero clear", 64'(cnt_zero_o), 0);

    for (int i = 0; i < 22; i++) begin
      vec_t v;
      string s;
      v = VECS[i];
      idle();
      match_valid_i = v.mv; match_tag_i = v.mt; match_type_i = v.mty;
      match_ibrk_i = v.mib; match_lbrk_i = v.mlb; match_addr_i = {16'h0, v.ma};
      flush_i = v.fl; ret_valid_i = v.rv; ret_tag_i = {v.rt1, v.rt0};
      tick();
      s = $sformatf("table row %0d", i);
      check({s, " rep_valid"}, 64'(rep_valid_o), 64'(v.erv));
      check({s, " rep_type"}, 64'(rep_type_o), 64'(v.eev));
      check({s, " brk_req"}, 64'(brk_req_o), 64'(v.eb));
      check({s, " brk_after"}, 64'(brk_after_o), 64'(v.ea));
      check({s, " brk_addr"}, 64'(brk_addr_o), 64'(v.eaddr));
    end
    // R3 R4 R5 R8: counts after table
    check("R3 R4 R5 R8 counters after table", cnt_o, {16'd4, 16'd3, 16'd4, 16'd3});

    // R10 saturation with a two-step decrement from one
    idle(); cnt_load_i = 4'h1; cnt_load_val_i = 16'd1;
    tick();
    check("R10 load one", 64'(cnt_o[15:0]), 1);
    put_match(3'd4, 4'h1);
    put_match(3'd5, 4'h1);
    retire2(3'd4, 3'd5);
    check("R4 dual report", 64'(rep_type_o), 64'h11);
    check("R10 saturate", 64'(cnt_o[15:0]), 0);
    check("R10 zero flag", 64'(cnt_zero_o[0]), 1);

    // R4 exact decrement by two
    idle(); cnt_load_i = 4'h8; cnt_load_val_i = 16'd9;
    tick();
    put_match(3'd6, 4'h8);
    put_match(3'd7, 4'h8);
    retire2(3'd6, 3'd7);
    check("R4 dec by two", 64'(cnt_o[63:48]), 7);

    // R10 load beats decrement
    put_match(3'd0, 4'h2);
    idle(); ret_valid_i = 2'b01; ret_tag_i = 6'd0;
    cnt_load_i = 4'h2; cnt_load_val_i = 16'd7;
    tick();
    check("R10 load priority report", 64'(rep_type_o), 64'h02);
    check("R10 load priority", 64'(cnt_o[31:16]), 7);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule